// File: doc/BRIEF.md
# Hardware Semaphore Bank

A bank of hardware semaphores that several bus masters share to guard common resources. Each request on a single-cycle register port carries a 4-bit master ID, which doubles as the requester's core ID. A semaphore can be taken in two ways. In the two-step method, software writes a lock request and then reads the word back to see whether it won. In the one-step method, a single read of a lock alias window takes the semaphore and returns the result. Both methods act on the same state bits.

The owner releases a semaphore by writing it with its own core and process IDs. A whole core's holdings can be released in one write, but only with a matching key. Every release sets a status bit in each interrupt group. Each group has its own enable mask, write-one-to-clear register, raw view, masked view and interrupt line. Only authorized master IDs may change any state. Identification and configuration words are constants.

A response comes back one cycle after each request, on the edge that also updates the state.

Top module: `hsem_bank`

## Requirements
- R1: After reset, every semaphore word, enable, status and the key read as zero, `rsp_valid_o` is 0 and every `irq_o` bit is 0.
- R2: A write from an authorized master to main word `i` (word address `i`) with bit 31 set, on a free semaphore, stores lock=1, core=master ID and proc=wdata[7:0]. A read of word `i` returns lock in bit 31, core in bits 11:8 and proc in bits 7:0. The read data appears on `rsp_rdata_o` with `rsp_valid_o`=1 in the cycle after the request.
- R3: A lock write to a semaphore that is already locked leaves its owner unchanged.
- R4: A read of alias word `0x20+i` from an authorized master locks a free semaphore with core=master ID and proc=0, and returns that new value. On a busy semaphore the read returns the current owner and changes nothing.
- R5: A write with bit 31 clear frees semaphore `i` only when the master ID equals the stored core and wdata[7:0] equals the stored proc. Any other release write has no effect.
- R6: A request from a master ID outside the four authorized IDs is discarded. Its writes change no register, and its alias reads return the current value without locking. The authorized IDs are four 4-bit parameter fields, and field k sits at bits 4k+3:4k of word 0xFB.
- R7: Each freed semaphore `i` sets bit `i` of the raw status in every group. Raw status of group g is at word 0x42+4g.
- R8: Masked status (word 0x43+4g) equals raw status AND enable (word 0x40+4g), and `irq_o[g]` is the OR of the masked bits.
- R9: Writing word 0x41+4g clears the raw status bits of group g that are 1 in the data. Bits written as 0 are untouched, and a read of that word returns 0.
- R10: A write to word 0x50 with core in bits 11:8 and key in bits 31:16 frees every semaphore owned by that core, and sets each one's status bits, only if the key equals the stored key. A wrong key changes nothing.
- R11: Word 0x51 holds the key in bits 31:16. It is writable and readable, and its bits 15:0 read as 0.
- R12: Word 0xFC reads the semaphore count in bits 7:0 and the group count in bits 11:8. Words 0xFD, 0xFE and 0xFF read constant parameters. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Word address (byte offset / 4) |
| req_wdata_i | input | 32 | Write data |
| req_master_i | input | 4 | Master ID, also used as the core ID |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | 32 | Read data, 0 for writes |
| irq_o | output | 2 | One interrupt line per group |

## Verification
Wrong internal state shows up at the next read of the affected word, one cycle after that read's request. This covers a lost owner, a lock granted to the wrong master, or a release that should not have happened. A status bit that fails to set, or fails to clear, shows on `irq_o` in the cycle after the release or clear write, as long as its enable bit is set. The directed tasks therefore read back every word they touch right after each write. They also read the alias window from a second master, where a wrongly freed semaphore would be granted to the wrong core.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int CORE_W   = 4;
  localparam int PROC_W   = 8;
  localparam int KEY_W    = 16;
  localparam int AUTH_N   = 4;
  localparam int LOCK_POS = 31;
  localparam int CORE_POS = 8;
  localparam int KEY_POS  = 16;

  typedef enum logic [3:0] {
    RG_NONE, RG_SEM, RG_ALIAS, RG_ENABLE, RG_CLEAR, RG_RAW, RG_MASKED,
    RG_BULK, RG_KEY, RG_AUTHCFG, RG_SIZECFG, RG_VERSION, RG_IDENT, RG_SIZEID
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [4:0] idx;
    logic [1:0] grp;
    logic       auth;
  } dec_t;

  function automatic logic [DATA_W-1:0] sem_word(input logic lk,
                                                 input logic [CORE_W-1:0] c,
                                                 input logic [PROC_W-1:0] p);
    logic [DATA_W-1:0] w;
    w = '0;
    w[LOCK_POS] = lk;
    w[CORE_POS +: CORE_W] = c;
    w[PROC_W-1:0] = p;
    return w;
  endfunction
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter logic [AUTH_N*CORE_W-1:0] AUTH_IDS = 16'h7321
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CORE_W-1:0] master_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '0;
    dec_o.region = RG_NONE;
    if (addr_i[7:5] == 3'b000) begin
      dec_o.region = RG_SEM;
      dec_o.idx    = addr_i[4:0];
    end else if (addr_i[7:5] == 3'b001) begin
      dec_o.region = RG_ALIAS;
      dec_o.idx    = addr_i[4:0];
    end else if (addr_i[7:4] == 4'b0100) begin
      dec_o.grp = addr_i[3:2];
      case (addr_i[1:0])
        2'd0:    dec_o.region = RG_ENABLE;
        2'd1:    dec_o.region = RG_CLEAR;
        2'd2:    dec_o.region = RG_RAW;
        default: dec_o.region = RG_MASKED;
      endcase
    end else begin
      case (addr_i)
        8'h50:   dec_o.region = RG_BULK;
        8'h51:   dec_o.region = RG_KEY;
        8'hFB:   dec_o.region = RG_AUTHCFG;
        8'hFC:   dec_o.region = RG_SIZECFG;
        8'hFD:   dec_o.region = RG_VERSION;
        8'hFE:   dec_o.region = RG_IDENT;
        8'hFF:   dec_o.region = RG_SIZEID;
        default: dec_o.region = RG_NONE;
      endcase
    end
    for (int k = 0; k < AUTH_N; k++) begin
      if (master_i == AUTH_IDS[k*CORE_W +: CORE_W]) dec_o.auth = 1'b1;
    end
  end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
  import hsem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lock_i,
  input  logic              wr_free_i,
  input  logic              rd_lock_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [PROC_W-1:0] proc_i,
  input  logic              bulk_i,
  input  logic [CORE_W-1:0] bulk_core_i,
  output logic              locked_o,
  output logic [CORE_W-1:0] core_o,
  output logic [PROC_W-1:0] proc_o,
  output logic              freed_o
);
  logic              locked_q;
  logic [CORE_W-1:0] core_q;
  logic [PROC_W-1:0] proc_q;
  logic              owner_free, bulk_free;

  assign owner_free = wr_free_i && (core_i == core_q) && (proc_i == proc_q);
  assign bulk_free  = bulk_i && (bulk_core_i == core_q);
  assign freed_o    = locked_q && (owner_free || bulk_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      core_q   <= '0;
      proc_q   <= '0;
    end else if (!locked_q) begin
      if (wr_lock_i) begin
        locked_q <= 1'b1;
        core_q   <= core_i;
        proc_q   <= proc_i;
      end else if (rd_lock_i) begin
        locked_q <= 1'b1;
        core_q   <= core_i;
        proc_q   <= '0;
      end
    end else if (freed_o) begin
      locked_q <= 1'b0;
      core_q   <= '0;
      proc_q   <= '0;
    end
  end

  assign locked_o = locked_q;
  assign core_o   = core_q;
  assign proc_o   = proc_q;

  // R3
  busy_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_lock_i) |=> (locked_q && $stable(core_q) && $stable(proc_q)));
  // R4
  alias_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && rd_lock_i && !wr_lock_i) |=> (locked_q && core_q == $past(core_i) && proc_q == '0));
  // R5
  foreign_free_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_free_i && core_i != core_q && !bulk_i) |=> locked_q);
endmodule

// File: rtl/hsem_irq_group.sv
module hsem_irq_group #(
  parameter int N_SEM = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [N_SEM-1:0] wdata_i,
  input  logic [N_SEM-1:0] set_i,
  output logic [N_SEM-1:0] enable_o,
  output logic [N_SEM-1:0] status_o,
  output logic             irq_o
);
  logic [N_SEM-1:0] enable_q, status_q;
  logic [N_SEM-1:0] clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (en_we_i) enable_q <= wdata_i;
      status_q <= (status_q & ~clr_mask) | set_i;
    end
  end

  assign enable_o = enable_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & enable_q);

  // R7
  raw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && set_i == '0) |=> ((status_q & $past(wdata_i)) == '0));
  // R9
  w1c_keep_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we_i |=> ((status_q & ~$past(wdata_i)) == ($past(status_q) & ~$past(wdata_i))));
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int                       N_SEM    = 32,
  parameter int                       N_GROUPS = 2,
  parameter logic [AUTH_N*CORE_W-1:0] AUTH_IDS = 16'h7321,
  parameter logic [DATA_W-1:0]        VERSION  = 32'h0000_0021,
  parameter logic [DATA_W-1:0]        IDENT    = 32'h5E4A_0001,
  parameter logic [DATA_W-1:0]        SIZE_ID  = 32'hA3C5_0F17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [CORE_W-1:0]   req_master_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [N_GROUPS-1:0] irq_o
);
  localparam int IW  = (N_SEM > 1) ? $clog2(N_SEM) : 1;
  localparam int GIW = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

  dec_t dec;
  hsem_decode #(.AUTH_IDS(AUTH_IDS)) u_dec (
    .addr_i(req_addr_i), .master_i(req_master_i), .dec_o(dec)
  );

  logic wr_ok, rd_ok, idx_ok, grp_ok;
  assign wr_ok  = req_valid_i && req_write_i && dec.auth;
  assign rd_ok  = req_valid_i && !req_write_i;
  assign idx_ok = (32'(dec.idx) < N_SEM);
  assign grp_ok = (32'(dec.grp) < N_GROUPS);

  logic [KEY_W-1:0] key_q;
  logic             bulk_go;
  assign bulk_go = wr_ok && dec.region == RG_BULK &&
                   req_wdata_i[KEY_POS +: KEY_W] == key_q;

  always_ff @(posedge clk) begin
    if (rst) key_q <= '0;
    else if (wr_ok && dec.region == RG_KEY) key_q <= req_wdata_i[KEY_POS +: KEY_W];
  end

  logic [N_SEM-1:0]  lock_vec, freed_vec;
  logic [CORE_W-1:0] core_arr [N_SEM];
  logic [PROC_W-1:0] proc_arr [N_SEM];

  for (genvar i = 0; i < N_SEM; i++) begin : g_sem
    logic hit;
    assign hit = (dec.idx == 5'(i));
    hsem_cell u_cell (
      .clk(clk), .rst(rst),
      .wr_lock_i(wr_ok && dec.region == RG_SEM && hit && req_wdata_i[LOCK_POS]),
      .wr_free_i(wr_ok && dec.region == RG_SEM && hit && !req_wdata_i[LOCK_POS]),
      .rd_lock_i(rd_ok && dec.auth && dec.region == RG_ALIAS && hit),
      .core_i(req_master_i), .proc_i(req_wdata_i[PROC_W-1:0]),
      .bulk_i(bulk_go), .bulk_core_i(req_wdata_i[CORE_POS +: CORE_W]),
      .locked_o(lock_vec[i]), .core_o(core_arr[i]), .proc_o(proc_arr[i]),
      .freed_o(freed_vec[i])
    );
  end

  logic [N_SEM-1:0] enable_arr [N_GROUPS];
  logic [N_SEM-1:0] status_arr [N_GROUPS];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic gsel;
    assign gsel = (dec.grp == 2'(g));
    hsem_irq_group #(.N_SEM(N_SEM)) u_grp (
      .clk(clk), .rst(rst),
      .en_we_i(wr_ok && dec.region == RG_ENABLE && gsel),
      .clr_we_i(wr_ok && dec.region == RG_CLEAR && gsel),
      .wdata_i(req_wdata_i[N_SEM-1:0]),
      .set_i(freed_vec),
      .enable_o(enable_arr[g]), .status_o(status_arr[g]), .irq_o(irq_o[g])
    );
  end

  logic [DATA_W-1:0] rd_mux, cur_word;
  logic [IW-1:0]     sidx;
  logic [GIW-1:0]    gidx;
  assign sidx     = dec.idx[IW-1:0];
  assign gidx     = dec.grp[GIW-1:0];
  assign cur_word = sem_word(lock_vec[sidx], core_arr[sidx], proc_arr[sidx]);

  always_comb begin
    rd_mux = '0;
    case (dec.region)
      RG_SEM:     if (idx_ok) rd_mux = cur_word;
      RG_ALIAS:   if (idx_ok) rd_mux = (dec.auth && !lock_vec[sidx]) ?
                                       sem_word(1'b1, req_master_i, '0) : cur_word;
      RG_ENABLE:  if (grp_ok) rd_mux = 32'(enable_arr[gidx]);
      RG_RAW:     if (grp_ok) rd_mux = 32'(status_arr[gidx]);
      RG_MASKED:  if (grp_ok) rd_mux = 32'(status_arr[gidx] & enable_arr[gidx]);
      RG_KEY:     rd_mux = 32'(key_q) << KEY_POS;
      RG_AUTHCFG: rd_mux = 32'(AUTH_IDS);
      RG_SIZECFG: rd_mux = 32'(N_SEM) | (32'(N_GROUPS) << 8);
      RG_VERSION: rd_mux = VERSION;
      RG_IDENT:   rd_mux = IDENT;
      RG_SIZEID:  rd_mux = SIZE_ID;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rd_ok ? rd_mux : '0;
    end
  end

  // R6
  unauth_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !dec.auth) |=> ($stable(lock_vec) && $stable(key_q)));
  // R10
  bulk_key_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && dec.region == RG_BULK &&
     req_wdata_i[KEY_POS +: KEY_W] != key_q) |=> $stable(lock_vec));
  // R5
  free_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_vec[0]) |-> $past(req_valid_i && req_write_i && dec.auth));
endmodule

// File: tb/hsem_bank_tb.sv
`timescale 1ns/100ps
module hsem_bank_tb;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_master = 0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsem_bank u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_master_i(req_master),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] m, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_master = m;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    r = rsp_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r;
    bus(1'b1, a, d, m, r);
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [3:0] m,
                          input logic [31:0] exp);
    logic [31:0] r;
    bus(1'b0, a, 32'h0, m, r);
    check(req, r, exp);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 irq", {30'b0, irq}, 32'h0);
    rd_check("R1 sem0", 8'h00, 4'h1, 32'h0);
    rd_check("R1 raw0", 8'h42, 4'h1, 32'h0);
    rd_check("R1 key", 8'h51, 4'h1, 32'h0);
    rd_check("R12 sizecfg", 8'hFC, 4'h1, 32'h0000_0220);
    rd_check("R6 authcfg", 8'hFB, 4'h1, 32'h0000_7321);
    rd_check("R12 version", 8'hFD, 4'h1, 32'h0000_0021);
    rd_check("R12 ident", 8'hFE, 4'h1, 32'h5E4A_0001);
    rd_check("R12 sizeid", 8'hFF, 4'h1, 32'hA3C5_0F17);
    rd_check("R12 unmapped", 8'h80, 4'h1, 32'h0);
  endtask

  task automatic t_two_step;
    logic [31:0] r;
    wr(8'h02, 32'h8000_00A5, 4'h1);
    bus(1'b0, 8'h02, 32'h0, 4'h1, r);
    check("R2 readback", r, 32'h8000_01A5);
    check("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic t_busy_write;
    wr(8'h02, 32'h8000_0033, 4'h2);
    rd_check("R3 busy write ignored", 8'h02, 4'h2, 32'h8000_01A5);
  endtask

  task automatic t_release;
    wr(8'h02, 32'h0000_0011, 4'h1);
    rd_check("R5 wrong proc", 8'h02, 4'h1, 32'h8000_01A5);
    wr(8'h02, 32'h0000_00A5, 4'h2);
    rd_check("R5 wrong core", 8'h02, 4'h1, 32'h8000_01A5);
    wr(8'h02, 32'h0000_00A5, 4'h1);
    rd_check("R5 owner free", 8'h02, 4'h1, 32'h0);
    rd_check("R7 raw group0", 8'h42, 4'h1, 32'h0000_0004);
    rd_check("R7 raw group1", 8'h46, 4'h1, 32'h0000_0004);
  endtask

  task automatic t_irq;
    wr(8'h40, 32'h0000_0004, 4'h1);
    rd_check("R8 masked0", 8'h43, 4'h1, 32'h0000_0004);
    rd_check("R8 masked1", 8'h47, 4'h1, 32'h0);
    check("R8 irq lines", {30'b0, irq}, 32'h1);
    wr(8'h41, 32'h0000_0000, 4'h1);
    rd_check("R9 zero write keeps", 8'h42, 4'h1, 32'h0000_0004);
    rd_check("R9 clear reads 0", 8'h41, 4'h1, 32'h0);
    wr(8'h41, 32'h0000_0004, 4'h1);
    rd_check("R9 cleared", 8'h42, 4'h1, 32'h0);
    check("R8 irq after clear", {30'b0, irq}, 32'h0);
    rd_check("R9 other group kept", 8'h46, 4'h1, 32'h0000_0004);
    wr(8'h45, 32'hFFFF_FFFF, 4'h1);
    rd_check("R9 group1 cleared", 8'h46, 4'h1, 32'h0);
  endtask

  task automatic t_read_lock;
    rd_check("R4 alias free", 8'h25, 4'h3, 32'h8000_0300);
    rd_check("R4 alias busy", 8'h25, 4'h2, 32'h8000_0300);
    rd_check("R4 main view", 8'h05, 4'h2, 32'h8000_0300);
  endtask

  task automatic t_unauth;
    wr(8'h03, 32'h8000_0012, 4'h5);
    rd_check("R6 unauth write", 8'h03, 4'h1, 32'h0);
    rd_check("R6 unauth alias", 8'h23, 4'h5, 32'h0);
    rd_check("R6 alias no lock", 8'h03, 4'h1, 32'h0);
    wr(8'h50, 32'h0000_0300, 4'h5);
    rd_check("R6 unauth bulk", 8'h05, 4'h1, 32'h8000_0300);
    wr(8'h44, 32'hFFFF_FFFF, 4'h5);
    rd_check("R6 unauth enable", 8'h44, 4'h1, 32'h0);
    wr(8'h51, 32'h1234_0000, 4'h5);
    rd_check("R6 unauth key", 8'h51, 4'h1, 32'h0);
  endtask

  task automatic t_bulk;
    wr(8'h51, 32'hBEEF_1234, 4'h1);
    rd_check("R11 key", 8'h51, 4'h1, 32'hBEEF_0000);
    wr(8'h00, 32'h8000_0001, 4'h3);
    wr(8'h01, 32'h8000_0002, 4'h3);
    wr(8'h06, 32'h8000_0009, 4'h2);
    wr(8'h50, 32'hBEEE_0300, 4'h1);
    rd_check("R10 wrong key", 8'h00, 4'h1, 32'h8000_0301);
    wr(8'h50, 32'hBEEF_0300, 4'h1);
    rd_check("R10 sem0 freed", 8'h00, 4'h1, 32'h0);
    rd_check("R10 sem1 freed", 8'h01, 4'h1, 32'h0);
    rd_check("R10 sem5 freed", 8'h05, 4'h1, 32'h0);
    rd_check("R10 other core kept", 8'h06, 4'h1, 32'h8000_0209);
    rd_check("R10 raw bits", 8'h42, 4'h1, 32'h0000_0023);
    rd_check("R10 raw bits g1", 8'h46, 4'h1, 32'h0000_0023);
    rd_check("R8 masked none", 8'h43, 4'h1, 32'h0);
    rd_check("R10 bulk reads 0", 8'h50, 4'h1, 32'h0);
  endtask

  task automatic t_last_sem;
    wr(8'h1F, 32'h8000_00FF, 4'h7);
    rd_check("R2 last sem", 8'h1F, 4'h1, 32'h8000_07FF);
    rd_check("R4 last alias busy", 8'h3F, 4'h1, 32'h8000_07FF);
    wr(8'h1F, 32'h0000_00FF, 4'h7);
    rd_check("R7 last raw", 8'h42, 4'h1, 32'h8000_0023);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_two_step();
    t_busy_write();
    t_release();
    t_irq();
    t_read_lock();
    t_unauth();
    t_bulk();
    t_last_sem();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule